// File: doc/BRIEF.md
# Prioritized Interrupt Autovector Unit

This block gathers fourteen interrupt requests that share one CPU interrupt line. Twelve of them are FIFO flags: programmable, empty and full for each of four endpoints. The other two come from the waveform engine: operation complete and waveform event. A rising edge on a request marks it pending. Software masks each source with an enable bit and acknowledges it with a write-one-to-clear strobe. The block then picks the highest-priority source that is both pending and enabled.

The winning source is turned into a vector byte. When autovectoring is on, that byte is spliced into the CPU's code-fetch data path at address 0x0055. The CPU's interrupt entry at 0x0053 holds a jump instruction, and its high address byte at 0x0054 comes from memory unchanged. The spliced low byte therefore completes a jump into a table of handlers.

The vector is frozen when the CPU fetches 0x0053. A request that arrives before the fetch of 0x0055 therefore cannot split the jump target.

Top module: `autovec_irq_unit`

## Requirements
- R1: Request bit `req_i[k]` is source k. Bits 0 to 3 are the programmable flags of endpoints 2, 4, 6 and 8. Bits 4 to 7 are the empty flags of the same endpoints, in the same order. Bits 8 to 11 are the full flags, in the same order. Bit 12 is waveform operation complete and bit 13 is waveform event. Among pending and enabled sources, the lowest bit index wins.
- R2: The vector byte of source k is 0x80 + 4*k, which runs from 0x80 for bit 0 to 0xB4 for bit 13.
- R3: A 0-to-1 transition of `req_i[k]` between two consecutive clock edges sets pending bit k. A request held high sets the bit only once; it does not set it again after a clear.
- R4: A strobe on `clr_i[k]` clears pending bit k at the next edge. If a new rising request for the same source arrives in that same cycle, the bit stays set.
- R5: The enable register is loaded from `cfg_en_i` when `cfg_we_i` is high. `irq_o` is the OR of the pending bits that are also enabled. Disabled sources never win the vector.
- R6: With autovectoring on, a valid code fetch of 0x0055 returns the winning vector byte instead of `mem_data_i`.
- R7: A fetch of 0x0054, and of any address other than 0x0055, returns `mem_data_i` unchanged.
- R8: With autovectoring off, a fetch of 0x0055 returns `mem_data_i` unchanged. The autovector bit is loaded from `cfg_av_i` when `cfg_we_i` is high.
- R9: A valid fetch of 0x0053 freezes the current vector. The next fetch of 0x0055 returns the frozen byte even if a higher-priority source became pending in between. That fetch releases the freeze.
- R10: When no enabled source is pending, `irq_o` is low and the vector byte is 0x80.
- R11: Reset clears all pending bits, all enables, the autovector bit and any freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 14 | Interrupt request levels, one per source |
| clr_i | input | 14 | Write-one-to-clear strobes for pending bits |
| cfg_we_i | input | 1 | Load strobe for enables and autovector bit |
| cfg_en_i | input | 14 | Per-source enable value |
| cfg_av_i | input | 1 | Autovector enable value |
| fetch_valid_i | input | 1 | CPU code fetch in progress |
| fetch_addr_i | input | 16 | CPU code fetch address |
| mem_data_i | input | 8 | Code memory read data |
| fetch_data_o | output | 8 | Fetch data seen by the CPU |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the fetch address and data inputs are stable while `fetch_valid_i` is high around an edge. They also assume that request levels change only between edges, so that the checker's own copy of the previous request level defines a rising edge in the same way as the design does.

The stimulus drives every input at the falling clock edge and holds fetches across exactly one rising edge. It deliberately places a request edge in the same cycle as its clear, and a higher-priority request between the entry fetch and the slot fetch.

// File: rtl/autovec_pkg.sv
package autovec_pkg;
    localparam int unsigned NUM_SRC    = 14;
    localparam int unsigned SRC_IW     = $clog2(NUM_SRC);
    localparam int unsigned ADDR_W     = 16;
    localparam int unsigned DATA_W     = 8;
    localparam logic [7:0]  VEC_BASE   = 8'h80;
    localparam logic [7:0]  VEC_STEP   = 8'h04;
    localparam logic [15:0] ENTRY_ADDR = 16'h0053;
    localparam logic [15:0] SLOT_ADDR  = 16'h0055;
endpackage

// File: rtl/autovec_pending.sv
module autovec_pending #(
    parameter int unsigned N = autovec_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clr_i,
    input  logic         cfg_we_i,
    input  logic [N-1:0] cfg_en_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] en_o
);
    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] prev;
        logic [N-1:0] en;
    } pend_state_t;

    pend_state_t st_d, st_q;
    logic [N-1:0] rise_w;

    // per-source edge detect and set/clear, set wins
    for (genvar k = 0; k < N; k++) begin : g_src
        assign rise_w[k] = req_i[k] & ~st_q.prev[k];
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = req_i;
        for (int k = 0; k < N; k++) begin
            st_d.pend[k] = (st_q.pend[k] & ~clr_i[k]) | rise_w[k];
        end
        if (cfg_we_i) begin
            st_d.en = cfg_en_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;
endmodule

// File: rtl/autovec_prio.sv
module autovec_prio #(
    parameter int unsigned N    = autovec_pkg::NUM_SRC,
    parameter int unsigned IW   = autovec_pkg::SRC_IW,
    parameter logic [7:0]  BASE = autovec_pkg::VEC_BASE,
    parameter logic [7:0]  STEP = autovec_pkg::VEC_STEP
) (
    input  logic [N-1:0]  pend_i,
    input  logic [N-1:0]  en_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o,
    output logic [7:0]    vec_o
);
    logic [N-1:0] live_w;

    assign live_w = pend_i & en_i;
    assign hit_o  = |live_w;

    // scan from lowest priority upward so the lowest index is kept last
    always_comb begin
        idx_o = '0;
        for (int k = int'(N) - 1; k >= 0; k--) begin
            if (live_w[k]) begin
                idx_o = IW'(k);
            end
        end
    end

    assign vec_o = hit_o ? (BASE + STEP * 8'(idx_o)) : BASE;
endmodule

// File: rtl/autovec_fetch.sv
module autovec_fetch #(
    parameter int unsigned AW    = autovec_pkg::ADDR_W,
    parameter int unsigned DW    = autovec_pkg::DATA_W,
    parameter logic [15:0] ENTRY = autovec_pkg::ENTRY_ADDR,
    parameter logic [15:0] SLOT  = autovec_pkg::SLOT_ADDR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we_i,
    input  logic          cfg_av_i,
    input  logic          fetch_valid_i,
    input  logic [AW-1:0] fetch_addr_i,
    input  logic [DW-1:0] mem_data_i,
    input  logic [DW-1:0] live_vec_i,
    output logic [DW-1:0] fetch_data_o,
    output logic          av_o
);
    typedef struct packed {
        logic          av;
        logic          held;
        logic [DW-1:0] frozen;
    } fetch_state_t;

    fetch_state_t st_d, st_q;
    logic at_entry_w, at_slot_w;

    assign at_entry_w = fetch_valid_i && (fetch_addr_i == AW'(ENTRY));
    assign at_slot_w  = fetch_valid_i && (fetch_addr_i == AW'(SLOT));

    always_comb begin
        st_d = st_q;
        if (cfg_we_i) begin
            st_d.av = cfg_av_i;
        end
        if (at_entry_w) begin
            st_d.held   = 1'b1;
            st_d.frozen = live_vec_i;
        end else if (at_slot_w) begin
            st_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        fetch_data_o = mem_data_i;
        if (st_q.av && at_slot_w) begin
            fetch_data_o = st_q.held ? st_q.frozen : live_vec_i;
        end
    end

    assign av_o = st_q.av;
endmodule

// File: rtl/autovec_irq_unit.sv
module autovec_irq_unit #(
    parameter int unsigned N  = autovec_pkg::NUM_SRC,
    parameter int unsigned AW = autovec_pkg::ADDR_W,
    parameter int unsigned DW = autovec_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic [N-1:0]  clr_i,
    input  logic          cfg_we_i,
    input  logic [N-1:0]  cfg_en_i,
    input  logic          cfg_av_i,
    input  logic          fetch_valid_i,
    input  logic [AW-1:0] fetch_addr_i,
    input  logic [DW-1:0] mem_data_i,
    output logic [DW-1:0] fetch_data_o,
    output logic          irq_o
);
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]  pend_w;
    logic [N-1:0]  en_w;
    logic          hit_w;
    logic [IW-1:0] idx_w;
    logic [7:0]    vec_w;
    logic          av_w;

    autovec_pending #(.N(N)) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .clr_i    (clr_i),
        .cfg_we_i (cfg_we_i),
        .cfg_en_i (cfg_en_i),
        .pend_o   (pend_w),
        .en_o     (en_w)
    );

    autovec_prio #(.N(N), .IW(IW)) u_prio (
        .pend_i (pend_w),
        .en_i   (en_w),
        .hit_o  (hit_w),
        .idx_o  (idx_w),
        .vec_o  (vec_w)
    );

    autovec_fetch #(.AW(AW), .DW(DW)) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we_i      (cfg_we_i),
        .cfg_av_i      (cfg_av_i),
        .fetch_valid_i (fetch_valid_i),
        .fetch_addr_i  (fetch_addr_i),
        .mem_data_i    (mem_data_i),
        .live_vec_i    (DW'(vec_w)),
        .fetch_data_o  (fetch_data_o),
        .av_o          (av_w)
    );

    assign irq_o = hit_w;
endmodule

// File: rtl/autovec_irq_unit_chk.sv
module autovec_irq_unit_chk #(
    parameter int unsigned N  = autovec_pkg::NUM_SRC,
    parameter int unsigned AW = autovec_pkg::ADDR_W,
    parameter int unsigned DW = autovec_pkg::DATA_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  req_i,
    input logic [N-1:0]  clr_i,
    input logic          fetch_valid_i,
    input logic [AW-1:0] fetch_addr_i,
    input logic [DW-1:0] mem_data_i,
    input logic [DW-1:0] fetch_data_o,
    input logic          irq_o,
    input logic [N-1:0]  pend,
    input logic [N-1:0]  en,
    input logic          av
);
    logic [N-1:0] seen_req;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_req <= '0;
        else        seen_req <= req_i;
    end

    for (genvar k = 0; k < N; k++) begin : g_chk
        // R3: a request edge sets the pending bit
        a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (req_i[k] && !seen_req[k]) |=> pend[k]);
        // R4: a clear with no new edge empties the bit
        a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !(req_i[k] && !seen_req[k])) |=> !pend[k]);
    end

    // R5 / R10: no interrupt without an enabled pending source
    a_r5_irq_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & en) == '0) |-> !irq_o);

    // R7: page byte is never altered
    a_r7_page_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_i && fetch_addr_i == AW'(16'h0054)) |-> fetch_data_o == mem_data_i);

    // R8: autovector off passes memory through
    a_r8_pass_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !av |-> fetch_data_o == mem_data_i);

    // R2: spliced byte lies on the vector grid
    a_r2_vector_grid: assert property (@(posedge clk) disable iff (!rst_n)
        (av && fetch_valid_i && fetch_addr_i == AW'(16'h0055))
        |-> (fetch_data_o[1:0] == 2'b00 && fetch_data_o >= DW'(8'h80) && fetch_data_o <= DW'(8'hB4)));
endmodule

bind autovec_irq_unit autovec_irq_unit_chk #(.N(N), .AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .clr_i         (clr_i),
    .fetch_valid_i (fetch_valid_i),
    .fetch_addr_i  (fetch_addr_i),
    .mem_data_i    (mem_data_i),
    .fetch_data_o  (fetch_data_o),
    .irq_o         (irq_o),
    .pend          (pend_w),
    .en            (en_w),
    .av            (av_w)
);

// File: tb/test_autovec_irq_unit.sv
module test_autovec_irq_unit;
    localparam int N = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic [N-1:0] clr_i = '0;
    logic        cfg_we_i = 1'b0;
    logic [N-1:0] cfg_en_i = '0;
    logic        cfg_av_i = 1'b0;
    logic        fetch_valid_i = 1'b0;
    logic [15:0] fetch_addr_i = '0;
    logic [7:0]  mem_data_i = '0;
    logic [7:0]  fetch_data_o;
    logic        irq_o;

    always #5 clk = ~clk;

    autovec_irq_unit i_autovec_irq_unit (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr_i),
        .cfg_we_i(cfg_we_i), .cfg_en_i(cfg_en_i), .cfg_av_i(cfg_av_i),
        .fetch_valid_i(fetch_valid_i), .fetch_addr_i(fetch_addr_i),
        .mem_data_i(mem_data_i), .fetch_data_o(fetch_data_o), .irq_o(irq_o)
    );

    typedef struct {
        string      tag;
        bit         is_irq;
        logic [7:0] exp;
    } item_t;

    item_t q[$];
    event  go;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    function automatic logic [7:0] vec_of(int k);
        return 8'h80 + 8'(4 * k);
    endfunction

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(go);
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it  = q.pop_front();
                got = it.is_irq ? {7'd0, irq_o} : fetch_data_o;
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic push(string tag, bit is_irq, logic [7:0] exp);
        item_t it;
        it.tag = tag; it.is_irq = is_irq; it.exp = exp;
        q.push_back(it);
        -> go;
    endtask

    task automatic expect_irq(string tag, bit exp);
        @(negedge clk);
        #1 push(tag, 1'b1, {7'd0, exp});
    endtask

    task automatic fetch(logic [15:0] a, logic [7:0] m, logic [7:0] exp, string tag);
        @(negedge clk);
        fetch_valid_i = 1'b1; fetch_addr_i = a; mem_data_i = m;
        #1 push(tag, 1'b0, exp);
        @(posedge clk);
        #1 fetch_valid_i = 1'b0;
    endtask

    task automatic cfg(logic [N-1:0] en, bit av);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_en_i = en; cfg_av_i = av;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic pulse(int k);
        @(negedge clk);
        req_i[k] = 1'b1;
        @(negedge clk);
        req_i[k] = 1'b0;
    endtask

    task automatic clear(logic [N-1:0] m);
        @(negedge clk);
        clr_i = m;
        @(negedge clk);
        clr_i = '0;
    endtask

    task automatic pulse_and_clear(int k);
        @(negedge clk);
        req_i[k] = 1'b1; clr_i = '0; clr_i[k] = 1'b1;
        @(negedge clk);
        req_i[k] = 1'b0; clr_i = '0;
    endtask

    initial begin
        #(20000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset state
        expect_irq("R11 irq low after reset", 1'b0);
        fetch(16'h0055, 8'h11, 8'h11, "R11/R8 autovector off after reset");

        cfg('1, 1'b1);
        // R10 idle vector
        expect_irq("R10 irq idle", 1'b0);
        fetch(16'h0055, 8'h22, vec_of(0), "R10 default vector");

        // R2/R6 single source
        pulse(5);
        expect_irq("R5 irq raised", 1'b1);
        fetch(16'h0055, 8'h22, vec_of(5), "R2/R6 vector of source 5");

        // R1 priority
        pulse(13);
        fetch(16'h0055, 8'h22, vec_of(5), "R1 lower index wins");
        clear(14'(1 << 5));
        fetch(16'h0055, 8'h22, vec_of(13), "R4/R2 after clear, top source 13");

        // R7 passthrough
        fetch(16'h0054, 8'h12, 8'h12, "R7 page byte untouched");
        fetch(16'h0155, 8'h33, 8'h33, "R7 other address untouched");

        // R9 freeze
        fetch(16'h0053, 8'h02, 8'h02, "R7 entry byte untouched");
        pulse(0);
        fetch(16'h0055, 8'h44, vec_of(13), "R9 frozen vector held");
        fetch(16'h0055, 8'h44, vec_of(0), "R9 freeze released");

        // R4 set wins over clear
        clear(14'(1 << 0));
        pulse_and_clear(2);
        fetch(16'h0055, 8'h44, vec_of(2), "R4 edge in clear cycle keeps pending");

        // R3 level held does not re-set
        clear(14'(1 << 2) | 14'(1 << 13));
        @(negedge clk) req_i[3] = 1'b1;
        expect_irq("R3 held request sets", 1'b1);
        clear(14'(1 << 3));
        expect_irq("R3 held request does not re-set", 1'b0);
        @(negedge clk) req_i[3] = 1'b0;

        // R5 enable mask
        cfg(~14'(1 << 1), 1'b1);
        pulse(1);
        expect_irq("R5 disabled source no irq", 1'b0);
        fetch(16'h0055, 8'h55, vec_of(0), "R5/R10 disabled source not a winner");
        pulse(4);
        fetch(16'h0055, 8'h55, vec_of(4), "R5 enabled source wins over disabled");

        // R8 autovector off
        cfg('1, 1'b0);
        fetch(16'h0055, 8'h66, 8'h66, "R8 autovector off passes memory");

        // R11 reset mid-run
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        expect_irq("R11 pending cleared", 1'b0);
        pulse(6);
        expect_irq("R11 enables cleared", 1'b0);

        @(negedge clk);
        #1 -> go;
        #1;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule